// File: doc/BRIEF.md
# Central-Limit Gaussian Sample Generator

This block emits one approximately normal, zero-mean, unit-variance random sample on every enabled clock. Twelve 16-bit pseudo-random shift registers each give a uniform fraction in [0,1). The sum of twelve such fractions has mean 6 and variance 1. The block subtracts 6 and presents the result as a signed fixed-point number. A jitter or noise injector can take one value per cycle from it, for example to drive a programmable delay element.

The block has no wide multi-operand adder. Each source is a Fibonacci (external-XOR) register that shifts right by one place per step and inserts one feedback bit at its top. So each step changes only one bit column across the twelve registers. A single 12-input ones counter measures that entering column. A 16-deep pipeline of 4-bit counts then slides down one weight position per step, so each column count is reused as its bits move toward the least significant end. The weighted sum of the sixteen counts equals the sum of the twelve words once sixteen steps have filled the pipeline.

Top module: `clt_gauss_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `valid` goes low. Every source k (k = 0..11) is loaded from the parameter `DEFAULT_SEED` through the R2 mapping, and all column counts clear.
- R2: Source k is loaded with `s ^ ((k+1)*16'h3C5B mod 2^16)`, where s is the seed being loaded. A result of zero is replaced by 16'hACE1.
- R3: On an enabled step, each source state x becomes `{x[0]^x[2]^x[3]^x[5], x[15:1]}`.
- R4: While `valid` is high, `sample` equals floor((S − 6·65536)/16) as a 16-bit two's-complement value, where S is the plain sum of the twelve 16-bit source words. This is a Q3.12 number.
- R5: After a reset or a seed load, `valid` stays low through the first 15 enabled steps and goes high on the 16th. It then stays high until the next reset or load.
- R6: With `en` and `load` both low, the source states, `sample` and `valid` do not change.
- R7: A high `load` takes priority over `en`. It loads all sources from `seed` per R2, drives `valid` low and restarts the R5 count.
- R8: Over 10,000 consecutive valid samples read as sample/4096, the mean lies within ±0.15 and the variance lies within 0.8 to 1.2.
- R9: `rst` takes priority over `load`. With both high, the sources take the `DEFAULT_SEED` values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance all sources and the count pipeline by one step |
| load | input | 1 | Reseed all sources from `seed` |
| seed | input | 16 | Base seed used by `load` |
| sample | output | 16 | Signed Q3.12 Gaussian sample |
| valid | output | 1 | The count pipeline is full and `sample` is exact |

## Verification
The bench keeps its own twelve-register model, built only from the shift and tap rule, and compares `sample` on every valid cycle with the directly summed words. A slip in column weighting, pipeline direction or the offset and shift would therefore appear within a few steps. It walks the fill boundary step by step. A fill counter that is off by one would raise `valid` one step early, while one column count is still zero, or one step late. It also loads a seed that makes source 0 zero: a missing zero substitution would lock that source at zero, and the running exact comparison would drift. Idle stretches, gapped enables and a reset that coincides with a load cover holding and priority. A long run checks that mean and variance stay near 0 and 1.

// File: rtl/clt_gauss_pkg.sv
`timescale 1ns/1ps
package clt_gauss_pkg;
  // Source register width; the feedback taps below assume this width.
  localparam int unsigned SRC_W     = 16;
  localparam logic [15:0] SEED_STEP = 16'h3C5B;
  localparam logic [15:0] ZERO_SUB  = 16'hACE1;

  // One Fibonacci step: right shift, feedback enters at the top bit.
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
  endfunction

  // Per-source seed derivation with all-zero substitution.
  function automatic logic [15:0] seed_for(input logic [15:0] seed, input int unsigned idx);
    logic [15:0] m;
    m = seed ^ 16'((idx + 1) * SEED_STEP);
    if (m == 16'h0000) m = ZERO_SUB;
    return m;
  endfunction
endpackage

// File: rtl/clt_lfsr_src.sv
`timescale 1ns/1ps
module clt_lfsr_src
  import clt_gauss_pkg::*;
#(
  parameter int unsigned IDX          = 0,
  parameter logic [15:0] DEFAULT_SEED = 16'hB5A3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        load,
  input  logic [15:0] seed,
  output logic [15:0] word,
  output logic        enter_bit
);
  // Bit that becomes the new MSB on the next enabled step.
  logic [15:0] next_word;
  assign next_word = lfsr_step(word);
  assign enter_bit = next_word[SRC_W-1];

  always_ff @(posedge clk) begin
    if (rst)       word <= seed_for(DEFAULT_SEED, IDX);
    else if (load) word <= seed_for(seed, IDX);
    else if (en)   word <= next_word;
  end
endmodule

// File: rtl/clt_ones_count.sv
`timescale 1ns/1ps
module clt_ones_count #(
  parameter int unsigned N  = 12,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + CW'(bits[i]);
  end
endmodule

// File: rtl/clt_col_pipe.sv
`timescale 1ns/1ps
module clt_col_pipe #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 4,
  parameter int unsigned SUM_W = DEPTH + CW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en,
  input  logic [CW-1:0]    top_count,
  output logic [SUM_W-1:0] weighted_sum
);
  logic [CW-1:0] col [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int i = 0; i < DEPTH; i++) col[i] <= '0;
    end else if (en) begin
      col[DEPTH-1] <= top_count;
      for (int i = 0; i < DEPTH - 1; i++) col[i] <= col[i+1];
    end
  end

  // Weight each column count by its power of two.
  always_comb begin
    weighted_sum = '0;
    for (int i = 0; i < DEPTH; i++)
      weighted_sum = weighted_sum + (SUM_W'(col[i]) << i);
  end
endmodule

// File: rtl/clt_fill_ctr.sv
`timescale 1ns/1ps
module clt_fill_ctr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned FW   = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic en,
  output logic full
);
  logic [FW-1:0] filled;

  always_ff @(posedge clk) begin
    if (rst || load)                    filled <= '0;
    else if (en && filled != FW'(DEPTH)) filled <= filled + 1'b1;
  end

  assign full = (filled == FW'(DEPTH));
endmodule

// File: rtl/clt_gauss_gen.sv
`timescale 1ns/1ps
module clt_gauss_gen
  import clt_gauss_pkg::*;
#(
  parameter int unsigned N_SRC        = 12,
  parameter int unsigned FRAC_BITS    = 12,
  parameter logic [15:0] DEFAULT_SEED = 16'hB5A3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        load,
  input  logic [15:0] seed,
  output logic [15:0] sample,
  output logic        valid
);
  localparam int unsigned CW    = $clog2(N_SRC + 1);
  localparam int unsigned SUM_W = SRC_W + CW;
  localparam int unsigned SHIFT = SRC_W - FRAC_BITS;
  localparam logic signed [SUM_W:0] OFFSET_V = (SUM_W + 1)'((N_SRC / 2) * (2 ** SRC_W));

  // Named internal events for the checker.
  logic [N_SRC*SRC_W-1:0] lfsr_bus;
  logic [N_SRC-1:0]       entering_bits;
  logic [CW-1:0]          entering_count;
  logic [SUM_W-1:0]       column_sum;
  logic                   pipe_full;

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    clt_lfsr_src #(.IDX(k), .DEFAULT_SEED(DEFAULT_SEED)) u_src (
      .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
      .word(lfsr_bus[k*SRC_W +: SRC_W]), .enter_bit(entering_bits[k])
    );
  end

  clt_ones_count #(.N(N_SRC), .CW(CW)) u_ones (
    .bits(entering_bits), .count(entering_count)
  );

  clt_col_pipe #(.DEPTH(SRC_W), .CW(CW), .SUM_W(SUM_W)) u_pipe (
    .clk(clk), .rst(rst), .clear(load), .en(en),
    .top_count(entering_count), .weighted_sum(column_sum)
  );

  clt_fill_ctr #(.DEPTH(SRC_W)) u_fill (
    .clk(clk), .rst(rst), .load(load), .en(en), .full(pipe_full)
  );

  // Remove the mean and rescale the fraction sum to the output format.
  function automatic logic [15:0] center_scale(input logic [SUM_W-1:0] s);
    logic signed [SUM_W:0] c;
    c = $signed({1'b0, s}) - OFFSET_V;
    c = c >>> SHIFT;
    return c[15:0];
  endfunction

  assign sample = center_scale(column_sum);
  assign valid  = pipe_full;
endmodule

// File: rtl/clt_gauss_checker.sv
`timescale 1ns/1ps
module clt_gauss_checker #(
  parameter int unsigned N_SRC     = 12,
  parameter int unsigned FRAC_BITS = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en,
  input logic                 load,
  input logic [15:0]          sample,
  input logic                 valid,
  input logic [N_SRC*16-1:0]  words
);
  localparam int unsigned SUM_W = 16 + $clog2(N_SRC + 1);

  // Direct word sum, taken from the registers rather than the column counts.
  function automatic logic [15:0] direct_sample(input logic [N_SRC*16-1:0] w);
    logic signed [SUM_W:0] acc;
    acc = '0;
    for (int k = 0; k < N_SRC; k++) acc = acc + $signed({{(SUM_W-15){1'b0}}, w[k*16 +: 16]});
    acc = acc - (SUM_W + 1)'((N_SRC / 2) * 65536);
    acc = acc >>> (16 - FRAC_BITS);
    return acc[15:0];
  endfunction

  logic [15:0] exp_sample;
  assign exp_sample = direct_sample(words);

  assert_sum_matches_R4: assert property (@(posedge clk) disable iff (rst)
    valid |-> (sample == exp_sample));

  assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (valid && !load) |=> valid);

  assert_valid_needs_step_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(en));

  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> ($stable(sample) && $stable(valid) && $stable(words)));

  assert_load_drops_valid_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> !valid);
endmodule

bind clt_gauss_gen clt_gauss_checker #(.N_SRC(N_SRC), .FRAC_BITS(FRAC_BITS)) u_chk (
  .clk(clk), .rst(rst), .en(en), .load(load),
  .sample(sample), .valid(valid), .words(lfsr_bus)
);

// File: tb/test_clt_gauss_gen.sv
`timescale 1ns/1ps
module test_clt_gauss_gen;
  localparam logic [15:0] DSEED = 16'hB5A3;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, load = 1'b0;
  logic [15:0] seed = '0;
  logic [15:0] sample;
  logic valid;

  always #2.5 clk = ~clk;

  clt_gauss_gen #(.N_SRC(12), .FRAC_BITS(12), .DEFAULT_SEED(DSEED)) i_clt_gauss_gen (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
    .sample(sample), .valid(valid)
  );

  int n_checks = 0, n_fail = 0;
  int mdl [12];
  int fill = 0;

  function automatic int mixed(input int s, input int k);
    int m;
    m = (s ^ ((k + 1) * 15451)) & 65535;   // 15451 = 0x3C5B
    if (m == 0) m = 44257;                   // 0xACE1
    return m;
  endfunction

  function automatic int advance(input int s);
    int b;
    b = (s ^ (s >> 2) ^ (s >> 3) ^ (s >> 5)) & 1;
    return (s >> 1) | (b << 15);
  endfunction

  function automatic int expect_sample();
    int s;
    s = 0;
    for (int k = 0; k < 12; k++) s += mdl[k];
    s = s - 6 * 65536;
    return s >>> 4;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; applies inputs, models the rising edge, returns at the next falling edge.
  task automatic tick(input logic r, input logic e, input logic l, input logic [15:0] sd);
    rst = r; en = e; load = l; seed = sd;
    @(posedge clk);
    if (r) begin
      for (int k = 0; k < 12; k++) mdl[k] = mixed(DSEED, k);
      fill = 0;
    end else if (l) begin
      for (int k = 0; k < 12; k++) mdl[k] = mixed(sd, k);
      fill = 0;
    end else if (e) begin
      for (int k = 0; k < 12; k++) mdl[k] = advance(mdl[k]);
      if (fill < 16) fill++;
    end
    @(negedge clk);
  endtask

  task automatic check_out(input string req);
    if (fill == 16) begin
      check(valid === 1'b1, {req, " valid"}, valid, 1);
      check($signed(sample) == expect_sample(), {req, " sample"}, $signed(sample), expect_sample());
    end else begin
      check(valid === 1'b0, {req, " valid"}, valid, 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] held_s;
    logic held_v;
    real sx, sxx, x, mean, var_x;
    @(negedge clk);

    // R1: reset state
    tick(1, 0, 0, 16'h0);
    check(valid === 1'b0, "R1 valid after reset", valid, 0);

    // R5 fill boundary, then R1/R2/R3/R4 exact sample from default seed
    for (int i = 0; i < 16; i++) begin
      tick(0, 1, 0, 16'h0);
      check_out("R5 fill after reset");
    end
    check(valid === 1'b1, "R5 valid on 16th step", valid, 1);
    check_out("R1 default seed");

    // R3/R4 free run
    for (int i = 0; i < 200; i++) begin
      tick(0, 1, 0, 16'h0);
      check_out("R3 R4 run");
    end

    // R6 idle holds
    held_s = sample; held_v = valid;
    for (int i = 0; i < 5; i++) begin
      tick(0, 0, 0, 16'h1234);
      check(sample === held_s, "R6 sample held", sample, held_s);
      check(valid === held_v, "R6 valid held", valid, held_v);
    end
    tick(0, 1, 0, 16'h0);
    check_out("R6 resume after idle");

    // R7 load with en high, R2 zero substitution for source 0
    tick(0, 1, 1, 16'h3C5B);
    check(valid === 1'b0, "R7 load drops valid", valid, 0);
    for (int i = 0; i < 40; i++) begin
      tick(0, 1, 0, 16'h0);
      check_out("R2 R7 reload");
    end

    // R9 reset beats load
    tick(1, 1, 1, 16'h5555);
    check(valid === 1'b0, "R9 reset with load", valid, 0);
    for (int i = 0; i < 30; i++) begin
      tick(0, 1, 0, 16'h0);
      check_out("R9 default after collision");
    end

    // R4/R5/R6 gapped enables after a load
    tick(0, 0, 1, 16'h9E01);
    for (int i = 0; i < 300; i++) begin
      tick(0, (i % 3) != 1, 0, 16'h0);
      check_out("R4 R6 gapped");
    end

    // R8 statistics
    sx = 0.0; sxx = 0.0;
    for (int i = 0; i < 10000; i++) begin
      tick(0, 1, 0, 16'h0);
      check_out("R4 stat run");
      x = $itor($signed(sample)) / 4096.0;
      sx += x; sxx += x * x;
    end
    mean = sx / 10000.0;
    var_x = sxx / 10000.0 - mean * mean;
    check(mean > -0.15 && mean < 0.15, "R8 mean x1000", $rtoi(mean * 1000.0), 0);
    check(var_x > 0.8 && var_x < 1.2, "R8 variance x1000", $rtoi(var_x * 1000.0), 1000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule